// File: doc/BRIEF.md
# Variable-Group Carry-Skip Adder

This block is a purely combinational binary adder with carry-in and carry-out. Its 32-bit core splits the carry path into nine groups of unequal length. Inside a group the carry ripples bit by bit. A group in which every bit position propagates hands its incoming carry straight on to the next group and does not wait for its own ripple. The groups are short at both ends of the word and long in the middle, so a carry that starts low, skips the middle and ripples into the top group meets a shorter worst path than it would with equal groups.

The group lengths are a design-time parameter table, checked at elaboration to add up to the core width. By default the top module widens the result to 64 bits with a carry-select stage. The lower half is one core. The upper half is built twice, once assuming a carry of 0 and once assuming a carry of 1, and the carry-out of the lower half picks between the two copies. A single-core 32-bit build is chosen by parameter.

Top module: `vskip_adder_top`

## Requirements
- R1: For any operands and carry-in, {carry_out, sum_out} equals op_a + op_b + carry_in taken over OUT_W+1 bits (OUT_W is 64 by default).
- R2: A carry generated at any bit k (both operands 1 at bit k, op_a 1 and op_b 0 at every higher bit, both 0 below k) travels through every higher group to carry_out = 1, and leaves sum_out equal to carry_in in bit 0 and 0 in every other bit.
- R3: When op_b is the bitwise complement of op_a, so that every group skips, a carry_in of 1 gives sum_out = 0 and carry_out = 1.
- R4: Under the same full-propagate operands, a carry_in of 0 gives sum_out with every bit 1 and carry_out = 0.
- R5: In the 64-bit build, bits 63..32 of sum_out equal op_a[63:32] + op_b[63:32] plus the carry out of the lower 32 bits, for a lower carry of both 0 and 1, and carry_out follows the same selected copy.
- R6: With both operands all ones, every bit generates: sum_out is all ones shifted left by one with carry_in in bit 0, and carry_out = 1.
- R7: With both operands zero, sum_out equals carry_in in bit 0 and 0 elsewhere, and carry_out = 0.
- R8: The block holds no state: when the inputs change, the outputs settle to the new result within the same cycle, and returning to earlier inputs returns the earlier result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | OUT_W | First operand |
| op_b | input | OUT_W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | OUT_W | Sum, modulo 2^OUT_W |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Two carry mechanisms can act on the same group for the same vector. One is the skip that forwards a group's carry-in, and the other is the ripple or a fresh generate inside that group. The carry-select choice at the half boundary also depends on the lower core's final skip. The bench provokes the overlap with full-propagate operands under both carry-in values. It does so with a carry born at each bit position in turn, so that every group boundary is crossed by skipping groups above the generating one. It also forces a lower-half overflow and then its absence under the same upper operands. Each result is judged against an arithmetic sum worked out in the bench, and also against the closed-form value stated in the requirement.

// File: rtl/vsk_pkg.sv
// Shared constants and elaboration-time helpers for the variable-group adder.
// Group lengths are packed 8 bits per group; group 0 (LSB side) sits in the
// lowest byte. Up to MAX_GRP groups are supported.
package vsk_pkg;

    localparam int unsigned LEN_BITS = 8;
    localparam int unsigned MAX_GRP  = 16;

    typedef logic [MAX_GRP*LEN_BITS-1:0] len_tab_t;

    // 1,3,4,5,6,5,4,3,1 from LSB to MSB (symmetric, sums to 32)
    localparam len_tab_t DEFAULT_LENS = len_tab_t'({8'd1, 8'd3, 8'd4, 8'd5, 8'd6,
                                                    8'd5, 8'd4, 8'd3, 8'd1});
    localparam int unsigned DEFAULT_NGRP = 9;

    // Length of group g taken from the packed table.
    function automatic int unsigned grp_len(input len_tab_t tab, input int unsigned g);
        return int'(tab[g*LEN_BITS +: LEN_BITS]);
    endfunction

    // Bit offset of group g: total length of all groups below it.
    function automatic int unsigned grp_ofs(input len_tab_t tab, input int unsigned g);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < g; i++) acc += grp_len(tab, i);
        return acc;
    endfunction

    // Total length of the first n groups.
    function automatic int unsigned grp_total(input len_tab_t tab, input int unsigned n);
        return grp_ofs(tab, n);
    endfunction

endpackage

// File: rtl/vsk_skip_group.sv
// One carry-skip group of LEN bits.
// Computes per-bit propagate and generate, ripples the carry through the
// group, and forwards the group carry-in straight to the carry-out when every
// bit propagates. Assumes LEN >= 1. Purely combinational.
module vsk_skip_group #(
    parameter int unsigned LEN = 4
) (
    input  logic [LEN-1:0] a,
    input  logic [LEN-1:0] b,
    input  logic           cin,
    output logic [LEN-1:0] sum,
    output logic           cout
);

    logic [LEN-1:0] prop;
    logic [LEN-1:0] gen;
    logic [LEN:0]   rip;
    logic           skip_en;

    // Per-bit propagate and generate terms.
    assign prop = a ^ b;
    assign gen  = a & b;

    // Local ripple of the carry through the group.
    always_comb begin
        rip[0] = cin;
        for (int i = 0; i < int'(LEN); i++) begin
            rip[i+1] = gen[i] | (prop[i] & rip[i]);
        end
    end

    // Skip condition: every position passes the carry.
    assign skip_en = &prop;

    // Sum bits from propagate and the carry into each position.
    assign sum  = prop ^ rip[LEN-1:0];

    // Group carry-out: bypass when skipping, otherwise the rippled carry.
    assign cout = skip_en ? cin : rip[LEN];

endmodule

// File: rtl/vsk_skip_chain.sv
// Single-level carry-skip adder of WIDTH bits built from NGRP groups whose
// lengths come from the packed table LENS. Assumes the lengths sum to WIDTH;
// elaboration stops with an error otherwise. Purely combinational.
module vsk_skip_chain
    import vsk_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned NGRP  = DEFAULT_NGRP,
    parameter len_tab_t    LENS  = DEFAULT_LENS
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int unsigned TOTAL = grp_total(LENS, NGRP);

    // Carries between groups; index g is the carry into group g.
    logic [NGRP:0] gcar;

    // Elaboration-time guard on the size table.
    if (TOTAL != WIDTH) begin : g_len_mismatch
        $error("vsk_skip_chain: group lengths add to %0d, width is %0d", TOTAL, WIDTH);
    end
    if (NGRP > MAX_GRP) begin : g_too_many
        $error("vsk_skip_chain: %0d groups exceed the table limit %0d", NGRP, MAX_GRP);
    end

    assign gcar[0] = cin;

    // One skip group per table entry, placed at its computed offset.
    for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
        localparam int unsigned LO = grp_ofs(LENS, g);
        localparam int unsigned LN = grp_len(LENS, g);
        vsk_skip_group #(.LEN(LN)) u_grp (
            .a    (a[LO +: LN]),
            .b    (b[LO +: LN]),
            .cin  (gcar[g]),
            .sum  (sum[LO +: LN]),
            .cout (gcar[g+1])
        );
    end

    // The top group's carry-out is the chain carry-out.
    assign cout = gcar[NGRP];

endmodule

// File: rtl/vsk_select_ext.sv
// Carry-select widening to 2*HALF bits. The lower half is one skip chain; the
// upper half is built twice, for an incoming carry of 0 and of 1, and the lower
// carry-out selects the result. Purely combinational.
module vsk_select_ext
    import vsk_pkg::*;
#(
    parameter int unsigned HALF = 32,
    parameter int unsigned NGRP = DEFAULT_NGRP,
    parameter len_tab_t    LENS = DEFAULT_LENS,
    localparam int unsigned W   = 2 * HALF
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [HALF-1:0] lo_sum;
    logic            lo_cout;
    logic [HALF-1:0] hi_sum0, hi_sum1;
    logic            hi_cout0, hi_cout1;

    // Lower half with the real carry-in.
    vsk_skip_chain #(.WIDTH(HALF), .NGRP(NGRP), .LENS(LENS)) u_lo (
        .a(a[HALF-1:0]), .b(b[HALF-1:0]), .cin(cin),
        .sum(lo_sum), .cout(lo_cout)
    );

    // Upper half assuming no carry from below.
    vsk_skip_chain #(.WIDTH(HALF), .NGRP(NGRP), .LENS(LENS)) u_hi0 (
        .a(a[W-1:HALF]), .b(b[W-1:HALF]), .cin(1'b0),
        .sum(hi_sum0), .cout(hi_cout0)
    );

    // Upper half assuming a carry from below.
    vsk_skip_chain #(.WIDTH(HALF), .NGRP(NGRP), .LENS(LENS)) u_hi1 (
        .a(a[W-1:HALF]), .b(b[W-1:HALF]), .cin(1'b1),
        .sum(hi_sum1), .cout(hi_cout1)
    );

    // Final select on the lower carry-out.
    always_comb begin
        sum[HALF-1:0] = lo_sum;
        if (lo_cout) begin
            sum[W-1:HALF] = hi_sum1;
            cout          = hi_cout1;
        end else begin
            sum[W-1:HALF] = hi_sum0;
            cout          = hi_cout0;
        end
    end

endmodule

// File: rtl/vskip_adder_top.sv
// Top of the variable-group carry-skip adder. WIDE_SELECT = 1 builds the
// 2*CHAIN_W carry-select variant; 0 builds a single CHAIN_W-bit chain.
// No clock and no state: outputs depend only on the current inputs.
module vskip_adder_top
    import vsk_pkg::*;
#(
    parameter bit          WIDE_SELECT = 1'b1,
    parameter int unsigned CHAIN_W     = 32,
    parameter int unsigned NGRP        = DEFAULT_NGRP,
    parameter len_tab_t    LENS        = DEFAULT_LENS,
    localparam int unsigned OUT_W      = WIDE_SELECT ? 2 * CHAIN_W : CHAIN_W
) (
    input  logic [OUT_W-1:0] op_a,
    input  logic [OUT_W-1:0] op_b,
    input  logic             carry_in,
    output logic [OUT_W-1:0] sum_out,
    output logic             carry_out
);

    // Variant choice fixed at elaboration.
    if (WIDE_SELECT) begin : g_wide
        vsk_select_ext #(.HALF(CHAIN_W), .NGRP(NGRP), .LENS(LENS)) u_sel (
            .a(op_a), .b(op_b), .cin(carry_in),
            .sum(sum_out), .cout(carry_out)
        );
    end else begin : g_narrow
        vsk_skip_chain #(.WIDTH(CHAIN_W), .NGRP(NGRP), .LENS(LENS)) u_chain (
            .a(op_a), .b(op_b), .cin(carry_in),
            .sum(sum_out), .cout(carry_out)
        );
    end

endmodule

// File: rtl/vskip_adder_chk.sv
// Assertion checker for vskip_adder_top, attached by bind below. The block is
// combinational, so the checks are immediate assertions evaluated whenever the
// ports settle, skipped while any input is unknown.
module vskip_adder_chk #(
    parameter int unsigned OUT_W   = 64,
    parameter int unsigned CHAIN_W = 32
) (
    input logic [OUT_W-1:0] op_a,
    input logic [OUT_W-1:0] op_b,
    input logic             carry_in,
    input logic [OUT_W-1:0] sum_out,
    input logic             carry_out
);

    logic [OUT_W:0] arith;

    // Whole-word arithmetic reference and closed-form cases.
    always_comb begin
        arith = {1'b0, op_a} + {1'b0, op_b} + {{OUT_W{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            p_sum_ref_r1: assert ({carry_out, sum_out} == arith)
                else $error("R1 sum mismatch");
            if ((op_a ^ op_b) == {OUT_W{1'b1}}) begin
                p_full_skip_r3: assert (carry_out == carry_in)
                    else $error("R3 full skip carry");
                p_skip_sum_r4: assert (sum_out == {OUT_W{~carry_in}})
                    else $error("R4 full skip sum");
            end
            if ((op_a & op_b) == {OUT_W{1'b1}}) begin
                p_all_gen_r6: assert (carry_out && sum_out == {{(OUT_W-1){1'b1}}, carry_in})
                    else $error("R6 all generate");
            end
            if (op_a == '0 && op_b == '0) begin
                p_zero_ops_r7: assert (!carry_out && sum_out == {{(OUT_W-1){1'b0}}, carry_in})
                    else $error("R7 zero operands");
            end
        end
    end

    // Upper half follows the lower carry in the carry-select build.
    if (OUT_W == 2 * CHAIN_W) begin : g_sel_chk
        logic [CHAIN_W:0] lo_part;
        logic [CHAIN_W:0] hi_part;
        always_comb begin
            lo_part = {1'b0, op_a[CHAIN_W-1:0]} + {1'b0, op_b[CHAIN_W-1:0]}
                    + {{CHAIN_W{1'b0}}, carry_in};
            hi_part = {1'b0, op_a[OUT_W-1:CHAIN_W]} + {1'b0, op_b[OUT_W-1:CHAIN_W]}
                    + {{CHAIN_W{1'b0}}, lo_part[CHAIN_W]};
            if (!$isunknown({op_a, op_b, carry_in})) begin
                p_select_hi_r5: assert ({carry_out, sum_out[OUT_W-1:CHAIN_W]} == hi_part)
                    else $error("R5 upper half select");
            end
        end
    end

endmodule

bind vskip_adder_top vskip_adder_chk #(.OUT_W(OUT_W), .CHAIN_W(CHAIN_W)) u_chk (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out)
);

// File: tb/vskip_adder_top_bench.sv
// Directed bench for vskip_adder_top (default 64-bit carry-select build).
module vskip_adder_top_bench;

    localparam int W = 64;
    localparam int H = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    vskip_adder_top u_vskip_adder_top (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum_out(sum_out), .carry_out(carry_out)
    );

    always #5 clk = ~clk;

    // Drive a vector away from the clock edge, then let it settle.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = ci;
        #3;
    endtask

    // Compare {carry_out,sum_out} with an expected value.
    task automatic cmp(input string req, input logic [W:0] exp);
        checks++;
        if ({carry_out, sum_out} !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, {carry_out, sum_out}, exp);
        end
    endtask

    function automatic logic [W:0] arith(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic ci);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    endfunction

    // R7: zero operands (the idle state after reset).
    task automatic t_zero;
        apply('0, '0, 1'b0); cmp("R7", {1'b0, {W{1'b0}}});
        apply('0, '0, 1'b1); cmp("R7", {1'b0, {(W-1){1'b0}}, 1'b1});
    endtask

    // R3/R4: every group propagates, carry skips the whole word.
    task automatic t_full_skip;
        logic [W-1:0] pats [4];
        pats[0] = '0;
        pats[1] = {W{1'b1}};
        pats[2] = 64'hA5A5_5A5A_F0F0_0F0F;
        pats[3] = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 4; i++) begin
            apply(pats[i], ~pats[i], 1'b1); cmp("R3", {1'b1, {W{1'b0}}});
            apply(pats[i], ~pats[i], 1'b0); cmp("R4", {1'b0, {W{1'b1}}});
        end
    endtask

    // R2: carry born at every bit, skipping all groups above it.
    task automatic t_carry_from_bit;
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] a, b;
            a = ~((64'd1 << k) - 64'd1);
            b = 64'd1 << k;
            apply(a, b, k[0]);
            cmp("R2", {1'b1, {(W-1){1'b0}}, k[0]});
        end
    endtask

    // R6: every bit generates.
    task automatic t_all_gen;
        apply({W{1'b1}}, {W{1'b1}}, 1'b0); cmp("R6", {1'b1, {(W-1){1'b1}}, 1'b0});
        apply({W{1'b1}}, {W{1'b1}}, 1'b1); cmp("R6", {1'b1, {W{1'b1}}});
    endtask

    // R5: same upper operands with and without a lower-half overflow.
    task automatic t_select;
        logic [H-1:0] ua [3];
        logic [H-1:0] ub [3];
        ua[0] = 32'hFFFF_FFFF; ub[0] = 32'h0000_0000;
        ua[1] = 32'h1234_5678; ub[1] = 32'h0FED_CBA9;
        ua[2] = 32'h8000_0000; ub[2] = 32'h7FFF_FFFF;
        for (int i = 0; i < 3; i++) begin
            logic [H:0] up;
            apply({ua[i], {H{1'b1}}}, {ub[i], {H{1'b0}}}, 1'b1);
            up = {1'b0, ua[i]} + {1'b0, ub[i]} + 33'd1;
            cmp("R5", {up, {H{1'b0}}});
            apply({ua[i], {H{1'b1}}}, {ub[i], {H{1'b0}}}, 1'b0);
            up = {1'b0, ua[i]} + {1'b0, ub[i]};
            cmp("R5", {up, {H{1'b1}}});
        end
    endtask

    // R1: pseudo-random operands against the arithmetic reference.
    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a, b;
            logic ci;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            ci = 1'($urandom);
            if (i % 4 == 1) b = ~a ^ (64'd1 << (i % W));
            apply(a, b, ci);
            cmp("R1", arith(a, b, ci));
        end
    endtask

    // R8: outputs follow the inputs back and forth with no memory.
    task automatic t_no_state;
        logic [W-1:0] a1, b1, a2, b2;
        a1 = 64'hDEAD_BEEF_0000_FFFF; b1 = 64'h0000_0001_FFFF_0001;
        a2 = 64'h7777_0000_1111_2222; b2 = 64'h0000_9999_0000_3333;
        apply(a1, b1, 1'b1); cmp("R8", arith(a1, b1, 1'b1));
        apply(a2, b2, 1'b0); cmp("R8", arith(a2, b2, 1'b0));
        apply(a1, b1, 1'b1); cmp("R8", arith(a1, b1, 1'b1));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero;
        t_full_skip;
        t_carry_from_bit;
        t_all_gen;
        t_select;
        t_random;
        t_no_state;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule